// File: doc/BRIEF.md
# Priority-Based Port Pin Multiplexer

This block arbitrates six shared port pins between a general-purpose I/O port and three peripheral functions: six PWM channels, a two-wire serial bus (clock and data) and a UART transmitter and receiver. For every pin it picks one owner by a fixed priority and drives the pad's output value, output enable and open-drain control. The PWM channel, the bus engine and the UART only supply enables and drive levels. The pads are reached only through this block.

Software sees two 8-bit registers on a simple write/read bus. Address 0 is the port data register and address 1 is the direction register. Each register holds six bits. Pad levels pass through a two-flop synchronizer. The synchronized levels feed data reads and the peripheral inputs: UART receive, bus clock and data, and PWM shutdown.

Top module: `port_pin_mux`

## Requirements
- R1: In reset and after reset, both registers hold zero. With every function enable low, every pad output enable is 0, so all pins are high-impedance inputs.
- R2: A pin owned by GPIO with direction bit 1 drives its data register bit with output enable 1 and open-drain 0. With direction bit 0 it is undriven.
- R3: A read at address 0 returns the register bit for pins whose direction bit is 1. For pins whose direction bit is 0 it returns the synchronized pad level, which appears on the read bus on the second rising edge after the pad changes.
- R4: Bits 7 and 6 of both registers read as 0, and writing 1s to them has no effect.
- R5: An enabled PWM channel i (pwm_en_i[i]=1) owns pin i and drives pwm_out_i[i] with output enable 1 and open-drain 0. This holds whatever the bus, UART and GPIO settings are, except in the case given in R6.
- R6: With pwm_en_i[5] and pwm_shdn_en_i both set, pin 5 is an undriven input and pwm_shdn_o follows its synchronized level. In every other case pwm_shdn_o is 0.
- R7: With the bus enabled, pin 5 (clock) and pin 4 (data) belong to the bus unless their own PWM channel is enabled. A bus pin has open-drain 1 and output value 0, and its output enable equals its drive-low request. bus_scl_o and bus_sda_o carry the synchronized pin level while the bus owns the pin, and 1 otherwise.
- R8: With the UART transmitter enabled and PWM channel 0 disabled, pin 0 drives uart_tx_i with output enable 1.
- R9: With the UART receiver enabled and PWM channel 2 disabled, pin 2 is an undriven input and uart_rx_o carries its synchronized level. Otherwise uart_rx_o is 1.
- R10: A write to the data register while a peripheral owns a pin updates the register bit but leaves that pin's drive unchanged.
- R11: Ownership is combinational. A change of any enable changes the pad controls in the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register select: 0 data, 1 direction |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for the selected register |
| pwm_en_i | input | 6 | Per-channel PWM enable |
| pwm_out_i | input | 6 | PWM output levels |
| pwm_shdn_en_i | input | 1 | Turns pin 5 into PWM shutdown input |
| pwm_shdn_o | output | 1 | Synchronized shutdown level |
| bus_en_i | input | 1 | Two-wire bus enable |
| bus_scl_low_i | input | 1 | Bus requests clock line low |
| bus_sda_low_i | input | 1 | Bus requests data line low |
| bus_scl_o | output | 1 | Synchronized clock line level |
| bus_sda_o | output | 1 | Synchronized data line level |
| uart_tx_en_i | input | 1 | UART transmitter enable |
| uart_tx_i | input | 1 | UART transmit level |
| uart_rx_en_i | input | 1 | UART receiver enable |
| uart_rx_o | output | 1 | Synchronized receive level |
| pad_in_i | input | 6 | Pad input levels |
| pad_out_o | output | 6 | Pad output values |
| pad_oe_o | output | 6 | Pad output enables |
| pad_od_o | output | 6 | Pad open-drain controls |

## Verification
The assertions take the enables and drive levels as settled by the time the clock samples them. They assume the register bus raises at most one write strobe per cycle with a stable address. Pad levels may change at any time, because they only enter the logic through the synchronizer. The bench changes every input on the falling edge and checks pad controls shortly after. External pad drive is applied only to pins that the block leaves undriven at that moment, so the modelled pull resolution never meets a conflict.

// File: rtl/port_pin_mux_pkg.sv
package port_pin_mux_pkg;
  typedef enum logic [2:0] {
    OWN_GPIO,
    OWN_PWM_OUT,
    OWN_PWM_IN,
    OWN_BUS,
    OWN_UART_TX,
    OWN_UART_RX
  } pin_owner_e;

  localparam logic ADDR_DATA = 1'b0;
  localparam logic ADDR_DIR  = 1'b1;
endpackage

// File: rtl/ppm_sync.sv
module ppm_sync #(
  parameter int W      = 6,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q[0] <= '0;
    else         stage_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else         stage_q[s] <= stage_q[s-1];
    end

    p_stage_shift_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> stage_q[s] == $past(stage_q[s-1]));
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/ppm_regs.sv
module ppm_regs
  import port_pin_mux_pkg::*;
#(
  parameter int W  = 6,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic          addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [W-1:0]  pin_sync_i,
  output logic [W-1:0]  data_o,
  output logic [W-1:0]  dir_o,
  output logic [DW-1:0] rdata_o
);
  localparam int PAD_W = DW - W;

  logic [W-1:0] data_q, dir_q, port_view;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      dir_q  <= '0;
    end else if (we_i) begin
      if (addr_i == ADDR_DATA) data_q <= wdata_i[W-1:0];
      else                     dir_q  <= wdata_i[W-1:0];
    end
  end

  // outputs read back the latch, inputs read the synchronized pad
  assign port_view = (dir_q & data_q) | (~dir_q & pin_sync_i);

  always_comb begin
    if (addr_i == ADDR_DATA) rdata_o = {{PAD_W{1'b0}}, port_view};
    else                     rdata_o = {{PAD_W{1'b0}}, dir_q};
  end

  assign data_o = data_q;
  assign dir_o  = dir_q;

  p_data_write_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_DATA) |=> data_q == $past(wdata_i[W-1:0]));

  p_dir_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_DIR) |=> dir_q == $past(wdata_i[W-1:0]));

  p_regs_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(data_q) && $stable(dir_q));
endmodule

// File: rtl/ppm_pin_ctrl.sv
module ppm_pin_ctrl
  import port_pin_mux_pkg::*;
#(
  parameter int NUM_PINS = 6,
  parameter int SCL_PIN  = 5,
  parameter int SDA_PIN  = 4,
  parameter int RX_PIN   = 2,
  parameter int TX_PIN   = 0,
  parameter int SHDN_PIN = 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pwm_en_i,
  input  logic [NUM_PINS-1:0] pwm_out_i,
  input  logic                pwm_shdn_en_i,
  input  logic                bus_en_i,
  input  logic                bus_scl_low_i,
  input  logic                bus_sda_low_i,
  input  logic                uart_tx_en_i,
  input  logic                uart_tx_i,
  input  logic                uart_rx_en_i,
  input  logic [NUM_PINS-1:0] gpio_data_i,
  input  logic [NUM_PINS-1:0] gpio_dir_i,
  input  logic [NUM_PINS-1:0] pin_sync_i,
  output logic [NUM_PINS-1:0] pad_out_o,
  output logic [NUM_PINS-1:0] pad_oe_o,
  output logic [NUM_PINS-1:0] pad_od_o,
  output logic                pwm_shdn_o,
  output logic                bus_scl_o,
  output logic                bus_sda_o,
  output logic                uart_rx_o
);
  logic [NUM_PINS-1:0] is_pwm_in, is_bus, is_rx;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    localparam bit IS_SCL  = (i == SCL_PIN);
    localparam bit IS_SDA  = (i == SDA_PIN);
    localparam bit IS_RX   = (i == RX_PIN);
    localparam bit IS_TX   = (i == TX_PIN);
    localparam bit IS_SHDN = (i == SHDN_PIN);

    pin_owner_e owner;
    logic out_b, oe_b, od_b, bus_low;

    assign bus_low = IS_SCL ? bus_scl_low_i : bus_sda_low_i;

    always_comb begin
      owner = OWN_GPIO;
      if (pwm_en_i[i])
        owner = (IS_SHDN && pwm_shdn_en_i) ? OWN_PWM_IN : OWN_PWM_OUT;
      else if (bus_en_i && (IS_SCL || IS_SDA))
        owner = OWN_BUS;
      else if (uart_rx_en_i && IS_RX)
        owner = OWN_UART_RX;
      else if (uart_tx_en_i && IS_TX)
        owner = OWN_UART_TX;
    end

    always_comb begin
      out_b = 1'b0;
      oe_b  = 1'b0;
      od_b  = 1'b0;
      unique case (owner)
        OWN_PWM_OUT: begin out_b = pwm_out_i[i]; oe_b = 1'b1; end
        OWN_PWM_IN:  ;
        OWN_BUS:     begin od_b = 1'b1; oe_b = bus_low; end
        OWN_UART_TX: begin out_b = uart_tx_i; oe_b = 1'b1; end
        OWN_UART_RX: ;
        default:     begin out_b = gpio_data_i[i]; oe_b = gpio_dir_i[i]; end
      endcase
    end

    assign pad_out_o[i] = out_b;
    assign pad_oe_o[i]  = oe_b;
    assign pad_od_o[i]  = od_b;
    assign is_pwm_in[i] = (owner == OWN_PWM_IN);
    assign is_bus[i]    = (owner == OWN_BUS);
    assign is_rx[i]     = (owner == OWN_UART_RX);

    p_pwm_wins_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pwm_en_i[i] && !(IS_SHDN && pwm_shdn_en_i)) |->
        (pad_oe_o[i] && !pad_od_o[i] && pad_out_o[i] == pwm_out_i[i]));

    p_od_never_high_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pad_od_o[i] |-> !(pad_oe_o[i] && pad_out_o[i]));
  end

  assign pwm_shdn_o = is_pwm_in[SHDN_PIN] & pin_sync_i[SHDN_PIN];
  assign bus_scl_o  = is_bus[SCL_PIN] ? pin_sync_i[SCL_PIN] : 1'b1;
  assign bus_sda_o  = is_bus[SDA_PIN] ? pin_sync_i[SDA_PIN] : 1'b1;
  assign uart_rx_o  = is_rx[RX_PIN]   ? pin_sync_i[RX_PIN]  : 1'b1;

  p_rx_undriven_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uart_rx_en_i && !pwm_en_i[RX_PIN]) |-> !pad_oe_o[RX_PIN]);

  p_shdn_undriven_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwm_en_i[SHDN_PIN] && pwm_shdn_en_i) |-> !pad_oe_o[SHDN_PIN]);

  p_tx_drives_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uart_tx_en_i && !pwm_en_i[TX_PIN]) |-> (pad_oe_o[TX_PIN] && pad_out_o[TX_PIN] == uart_tx_i));
endmodule

// File: rtl/port_pin_mux.sv
module port_pin_mux #(
  parameter int NUM_PINS    = 6,
  parameter int REG_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                reg_we_i,
  input  logic                reg_addr_i,
  input  logic [REG_W-1:0]    reg_wdata_i,
  output logic [REG_W-1:0]    reg_rdata_o,
  input  logic [NUM_PINS-1:0] pwm_en_i,
  input  logic [NUM_PINS-1:0] pwm_out_i,
  input  logic                pwm_shdn_en_i,
  output logic                pwm_shdn_o,
  input  logic                bus_en_i,
  input  logic                bus_scl_low_i,
  input  logic                bus_sda_low_i,
  output logic                bus_scl_o,
  output logic                bus_sda_o,
  input  logic                uart_tx_en_i,
  input  logic                uart_tx_i,
  input  logic                uart_rx_en_i,
  output logic                uart_rx_o,
  input  logic [NUM_PINS-1:0] pad_in_i,
  output logic [NUM_PINS-1:0] pad_out_o,
  output logic [NUM_PINS-1:0] pad_oe_o,
  output logic [NUM_PINS-1:0] pad_od_o
);
  logic [NUM_PINS-1:0] pin_sync, gpio_data, gpio_dir;

  ppm_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pad_in_i),
    .q_o    (pin_sync)
  );

  ppm_regs #(.W(NUM_PINS), .DW(REG_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .pin_sync_i (pin_sync),
    .data_o     (gpio_data),
    .dir_o      (gpio_dir),
    .rdata_o    (reg_rdata_o)
  );

  ppm_pin_ctrl #(.NUM_PINS(NUM_PINS)) u_pin_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .pwm_en_i      (pwm_en_i),
    .pwm_out_i     (pwm_out_i),
    .pwm_shdn_en_i (pwm_shdn_en_i),
    .bus_en_i      (bus_en_i),
    .bus_scl_low_i (bus_scl_low_i),
    .bus_sda_low_i (bus_sda_low_i),
    .uart_tx_en_i  (uart_tx_en_i),
    .uart_tx_i     (uart_tx_i),
    .uart_rx_en_i  (uart_rx_en_i),
    .gpio_data_i   (gpio_data),
    .gpio_dir_i    (gpio_dir),
    .pin_sync_i    (pin_sync),
    .pad_out_o     (pad_out_o),
    .pad_oe_o      (pad_oe_o),
    .pad_od_o      (pad_od_o),
    .pwm_shdn_o    (pwm_shdn_o),
    .bus_scl_o     (bus_scl_o),
    .bus_sda_o     (bus_sda_o),
    .uart_rx_o     (uart_rx_o)
  );

  always @(negedge clk_i) begin
    if (!rst_ni && pwm_en_i == '0 && !bus_en_i && !uart_tx_en_i && !uart_rx_en_i)
      p_reset_hiz_r1: assert (pad_oe_o == '0);
  end
endmodule

// File: tb/port_pin_mux_bench.sv
module port_pin_mux_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       reg_we_i = 1'b0;
  logic       reg_addr_i = 1'b0;
  logic [7:0] reg_wdata_i = '0;
  logic [7:0] reg_rdata_o;
  logic [5:0] pwm_en_i = '0, pwm_out_i = '0;
  logic       pwm_shdn_en_i = 1'b0, pwm_shdn_o;
  logic       bus_en_i = 1'b0, bus_scl_low_i = 1'b0, bus_sda_low_i = 1'b0;
  logic       bus_scl_o, bus_sda_o;
  logic       uart_tx_en_i = 1'b0, uart_tx_i = 1'b0, uart_rx_en_i = 1'b0, uart_rx_o;
  logic [5:0] pad_lvl, pad_out_o, pad_oe_o, pad_od_o;
  logic [5:0] ext_en = '0, ext_val = '0;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  // pad: block drive, else external drive, else pull-up
  always_comb begin
    for (int k = 0; k < 6; k++)
      pad_lvl[k] = pad_oe_o[k] ? pad_out_o[k] : (ext_en[k] ? ext_val[k] : 1'b1);
  end

  port_pin_mux u_port_pin_mux (
    .clk_i, .rst_ni, .reg_we_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .pwm_en_i, .pwm_out_i, .pwm_shdn_en_i, .pwm_shdn_o,
    .bus_en_i, .bus_scl_low_i, .bus_sda_low_i, .bus_scl_o, .bus_sda_o,
    .uart_tx_en_i, .uart_tx_i, .uart_rx_en_i, .uart_rx_o,
    .pad_in_i(pad_lvl), .pad_out_o, .pad_oe_o, .pad_od_o
  );

  typedef struct packed {
    logic [5:0] pwm_en, pwm_out;
    logic       shdn, bus, scl_low, sda_low, tx_en, tx, rx_en;
    logic [5:0] data, dir, oe, out, od;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{6'b000000, 6'b000000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 6'b101010, 6'b111100, 6'b111100, 6'b101000, 6'b000000},
    '{6'b111111, 6'b010101, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 6'b000000, 6'b000000, 6'b111111, 6'b010101, 6'b000000},
    '{6'b100000, 6'b100000, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 6'b000000, 6'b000000, 6'b010000, 6'b000000, 6'b010000},
    '{6'b000000, 6'b000000, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 6'b111111, 6'b111111, 6'b101011, 6'b001011, 6'b110000},
    '{6'b000101, 6'b000000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 6'b000000, 6'b111111, 6'b111111, 6'b000000, 6'b000000},
    '{6'b000000, 6'b000000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 6'b000100, 6'b000100, 6'b000101, 6'b000100, 6'b000000},
    '{6'b010000, 6'b010000, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 6'b000000, 6'b000000, 6'b010000, 6'b010000, 6'b100000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    reg_addr_i = a;
    #1;
    d = reg_rdata_o;
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] r;
    // R1: reset state
    repeat (3) @(negedge clk_i);
    check("R1 oe in reset", pad_oe_o, 6'h00);
    rd(1'b1, r); check("R1 dir in reset", r, 8'h00);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    check("R1 oe after reset", pad_oe_o, 6'h00);
    rd(1'b0, r); check("R1 R3 pulled-up inputs read", r, 8'h3F);

    // R4: unimplemented bits
    wr(1'b1, 8'hFF);
    rd(1'b1, r); check("R4 dir upper bits", r, 8'h3F);
    wr(1'b0, 8'hFF);
    rd(1'b0, r); check("R4 data upper bits", r, 8'h3F);
    wr(1'b0, 8'h00);
    wr(1'b1, 8'h00);

    // R2 R5 R7 R8 R9: ownership table
    for (int v = 0; v < NV; v++) begin
      wr(1'b0, {2'b00, VECS[v].data});
      wr(1'b1, {2'b00, VECS[v].dir});
      pwm_en_i = VECS[v].pwm_en; pwm_out_i = VECS[v].pwm_out;
      pwm_shdn_en_i = VECS[v].shdn; bus_en_i = VECS[v].bus;
      bus_scl_low_i = VECS[v].scl_low; bus_sda_low_i = VECS[v].sda_low;
      uart_tx_en_i = VECS[v].tx_en; uart_tx_i = VECS[v].tx; uart_rx_en_i = VECS[v].rx_en;
      #1;
      check($sformatf("R2 R5 R7 R8 vec%0d oe", v), pad_oe_o, VECS[v].oe);
      check($sformatf("R2 R5 R7 R8 vec%0d out", v), pad_out_o & pad_oe_o, VECS[v].out);
      check($sformatf("R7 vec%0d od", v), pad_od_o, VECS[v].od);
    end
    pwm_en_i = '0; pwm_shdn_en_i = 0; bus_en_i = 0; bus_scl_low_i = 0; bus_sda_low_i = 0;
    uart_tx_en_i = 0; uart_tx_i = 0; uart_rx_en_i = 0;
    wr(1'b1, 8'h00);

    // R3: input read latency through synchronizer
    @(negedge clk_i); ext_en[3] = 1'b1; ext_val[3] = 1'b0;
    @(posedge clk_i); #1; rd(1'b0, r); check("R3 one edge still old", r, 8'h3F);
    @(posedge clk_i); #1; rd(1'b0, r); check("R3 two edges new", r, 8'h37);
    ext_en = '0;

    // R10 R11: write while bus owns pins, then release
    wr(1'b1, 8'h3F);
    wr(1'b0, 8'h3F);
    @(negedge clk_i); bus_en_i = 1'b1;
    #1; check("R11 bus takes pin5 same cycle", pad_oe_o[5], 1'b0);
    wr(1'b0, 8'h00);
    check("R10 pin5 unaffected by write", pad_oe_o[5], 1'b0);
    rd(1'b0, r); check("R10 register updated", r, 8'h00);
    @(negedge clk_i); bus_en_i = 1'b0;
    #1; check("R11 R10 gpio back same cycle", {pad_oe_o[5], pad_out_o[5]}, 2'b10);

    // R7: bus clock input path
    wr(1'b1, 8'h00);
    @(negedge clk_i); bus_en_i = 1'b1; ext_en[5] = 1'b1; ext_val[5] = 1'b0;
    repeat (2) @(posedge clk_i); #1;
    check("R7 scl follows pin", bus_scl_o, 1'b0);
    check("R7 sda released high", bus_sda_o, 1'b1);
    @(negedge clk_i); bus_en_i = 1'b0; #1;
    check("R7 scl idle when not owned", bus_scl_o, 1'b1);

    // R6: shutdown input
    @(negedge clk_i); pwm_en_i = 6'b100000; pwm_shdn_en_i = 1'b1; ext_val[5] = 1'b1;
    repeat (2) @(posedge clk_i); #1;
    check("R6 shutdown high", pwm_shdn_o, 1'b1);
    @(negedge clk_i); ext_val[5] = 1'b0;
    repeat (2) @(posedge clk_i); #1;
    check("R6 shutdown low", pwm_shdn_o, 1'b0);
    @(negedge clk_i); ext_en[5] = 1'b0; pwm_shdn_en_i = 1'b0; #1;
    check("R6 pin5 driven again", pad_oe_o[5], 1'b1);
    repeat (2) @(posedge clk_i); #1;
    check("R6 shutdown off when not input", pwm_shdn_o, 1'b0);
    @(negedge clk_i); pwm_en_i = '0;

    // R9: receive path
    @(negedge clk_i); uart_rx_en_i = 1'b1; ext_en[2] = 1'b1; ext_val[2] = 1'b0;
    repeat (2) @(posedge clk_i); #1;
    check("R9 rx follows pin", uart_rx_o, 1'b0);
    @(negedge clk_i); uart_rx_en_i = 1'b0; #1;
    check("R9 rx idle when disabled", uart_rx_o, 1'b1);
    ext_en = '0;

    finish_run();
  end
endmodule